// File: doc/BRIEF.md
# Subroutine Linkage Sequencer

This block carries out the three subroutine-linkage instructions of a 16-bit machine whose PC and stack pointer live in a general register file: a call through an arbitrary linkage register, a return through a named register, and a frame-cleanup that discards a counted block of stack parameters. Instruction decode, the effective-address calculation and the register file itself are outside the block. The effective address reaches it precomputed. The register file and a word-wide memory port with request/acknowledge are its only state.

A pulse on `start` with a recognised instruction starts a sequence. The sequence updates the register file one write per cycle and makes at most one memory access, holding each access until it is acknowledged. The final register write is marked by `done`. A call whose destination field selects register mode 0 performs no work and instead raises a one-cycle request for the illegal-instruction trap (vector 4). The trap itself is delivered elsewhere. The block never touches condition codes. Its only side effects are the writes it places on the register-file port and the memory port.

Top module: `link_seq`

## Requirements
- R1: On `start` in the idle state, bits 15:9 = 0000100 select a call (linkage register in bits 8:6, destination mode in bits 5:3), bits 15:3 = 0000000010000 select a return through register bits 2:0, and bits 15:6 = 0000110100 select a cleanup with count bits 5:0. Any other word produces no register write, no memory access, no `done` and no trap request.
- R2: A call with a non-zero destination mode performs, in this order: SP (register 6) ← SP − 2; memory write of the old linkage-register value at the new SP; linkage register ← old PC (register 7); PC ← destination address.
- R3: A call whose linkage register is 7 omits the linkage-register write: SP ← SP − 2, push of old PC, then PC ← destination.
- R4: A return through register r performs, in this order: PC ← R[r]; memory read at SP; SP ← SP + 2; R[r] ← data read.
- R5: A cleanup with count n performs, in this order: SP ← PC + 2·n; PC ← R5; memory read at the new SP; SP ← that SP + 2; R5 ← data read.
- R6: A call whose destination mode (bits 5:3) is 0 raises `illegal_req` for exactly one cycle, with no register write, memory access or `done`.
- R7: Each memory access holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ack`, and the sequence does not advance until the acknowledge arrives, whatever the latency.
- R8: `done` is high for exactly one cycle, together with the final register write of each call, return or cleanup.
- R9: `start` is ignored while a sequence is in progress.
- R10: During reset, `rf_we`, `mem_req`, `done` and `illegal_req` are all low.
- R11: The destination address is captured in the `start` cycle. Later changes of `dest_addr` do not alter the PC written by the call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin executing `instr` (idle state only) |
| instr | input | 16 | Instruction word |
| dest_addr | input | 16 | Precomputed destination address for a call |
| rf_raddr | output | 3 | Register-file read index (linkage register) |
| rf_rdata | input | 16 | Register-file read data for `rf_raddr` |
| sp_in | input | 16 | Current stack pointer (register 6) |
| pc_in | input | 16 | Current PC (register 7), already past the instruction |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 3 | Register-file write index |
| rf_wdata | output | 16 | Register-file write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| done | output | 1 | Final register write of a sequence |
| illegal_req | output | 1 | Request for the illegal-instruction trap |

## Verification
The awkward cases are those where the linkage register is also the PC, or where the return register is the PC, because the same index is then written twice or not at all. Another hard case is a cleanup whose pop address depends on an SP value written two cycles earlier. The bench drives these through a behavioural register file and memory that feed the results back to the ports. It uses acknowledge latencies from zero to three cycles, and it changes `dest_addr` and pulses `start` again in the middle of a sequence. A scoreboard with ordered expectations flags any write that should not happen.

// File: rtl/sls_pkg.sv
package sls_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TRAP,
    ST_C_SPDEC,
    ST_C_PUSH,
    ST_C_LINK,
    ST_C_JUMP,
    ST_R_PC,
    ST_M_SP,
    ST_M_PC,
    ST_P_READ,
    ST_P_INC,
    ST_P_WRITE
  } seq_state_t;

  localparam logic [6:0]  OPC_CALL = 7'b0000100;
  localparam logic [12:0] OPC_RET  = 13'b0000000010000;
  localparam logic [9:0]  OPC_MARK = 10'b0000110100;

endpackage

// File: rtl/sls_decode.sv
module sls_decode
  import sls_pkg::*;
#(
  parameter int REG_W  = 3,
  parameter int FP_IDX = 5
) (
  input  logic [15:0]      instr,
  output logic             is_call,
  output logic             is_ret,
  output logic             is_mark,
  output logic             call_bad,
  output logic [REG_W-1:0] reg_sel,
  output logic [5:0]       count
);

  always_comb begin
    is_call  = (instr[15:9] == OPC_CALL);
    is_ret   = (instr[15:3] == OPC_RET);
    is_mark  = (instr[15:6] == OPC_MARK);
    call_bad = is_call && (instr[5:3] == 3'd0);
    count    = instr[5:0];
    if (is_call)
      reg_sel = REG_W'(instr[8:6]);
    else if (is_ret)
      reg_sel = REG_W'(instr[2:0]);
    else
      reg_sel = REG_W'(FP_IDX);
  end

endmodule

// File: rtl/sls_ctrl.sv
module sls_ctrl
  import sls_pkg::*;
#(
  parameter int REG_W  = 3,
  parameter int PC_IDX = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_call,
  input  logic             is_ret,
  input  logic             is_mark,
  input  logic             call_bad,
  input  logic [REG_W-1:0] reg_q,
  input  logic             mem_ack,
  output seq_state_t       state_q
);

  seq_state_t state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (call_bad)     state_d = ST_TRAP;
          else if (is_call) state_d = ST_C_SPDEC;
          else if (is_ret)  state_d = ST_R_PC;
          else if (is_mark) state_d = ST_M_SP;
        end
      end
      ST_TRAP:    state_d = ST_IDLE;
      ST_C_SPDEC: state_d = ST_C_PUSH;
      ST_C_PUSH: begin
        if (mem_ack)
          state_d = (reg_q == REG_W'(PC_IDX)) ? ST_C_JUMP : ST_C_LINK;
      end
      ST_C_LINK:  state_d = ST_C_JUMP;
      ST_C_JUMP:  state_d = ST_IDLE;
      ST_R_PC:    state_d = ST_P_READ;
      ST_M_SP:    state_d = ST_M_PC;
      ST_M_PC:    state_d = ST_P_READ;
      ST_P_READ: begin
        if (mem_ack) state_d = ST_P_INC;
      end
      ST_P_INC:   state_d = ST_P_WRITE;
      ST_P_WRITE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/sls_dpath.sv
module sls_dpath
  import sls_pkg::*;
#(
  parameter int DW     = 16,
  parameter int REG_W  = 3,
  parameter int SP_IDX = 6,
  parameter int PC_IDX = 7,
  parameter int STEP   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_state_t       state_q,
  input  logic             start,
  input  logic [DW-1:0]    dest_addr,
  input  logic [REG_W-1:0] reg_sel,
  input  logic [5:0]       count,
  input  logic [DW-1:0]    rf_rdata,
  input  logic [DW-1:0]    sp_in,
  input  logic [DW-1:0]    pc_in,
  input  logic             mem_ack,
  input  logic [DW-1:0]    mem_rdata,
  output logic [REG_W-1:0] reg_q,
  output logic             rf_we,
  output logic [REG_W-1:0] rf_waddr,
  output logic [DW-1:0]    rf_wdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             done,
  output logic             illegal_req
);

  localparam logic [DW-1:0]    STEP_V = DW'(STEP);
  localparam logic [REG_W-1:0] SP_A   = REG_W'(SP_IDX);
  localparam logic [REG_W-1:0] PC_A   = REG_W'(PC_IDX);

  logic [DW-1:0] tgt_q;
  logic [5:0]    cnt_q;
  logic [DW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          ld_start, ld_addr, ld_data;
  logic [DW-1:0] mark_off;

  assign ld_start = (state_q == ST_IDLE) && start;
  assign mark_off = DW'(cnt_q) * STEP_V;

  // enables and next values of the address/data holding registers
  always_comb begin
    ld_addr = 1'b0;
    ld_data = 1'b0;
    addr_d  = addr_q;
    data_d  = data_q;
    unique case (state_q)
      ST_C_SPDEC: begin
        ld_addr = 1'b1;
        addr_d  = sp_in - STEP_V;
        ld_data = 1'b1;
        data_d  = rf_rdata;
      end
      ST_R_PC, ST_M_PC: begin
        ld_addr = 1'b1;
        addr_d  = sp_in;
      end
      ST_P_READ: begin
        ld_data = mem_ack;
        data_d  = mem_rdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      reg_q <= '0;
      cnt_q <= '0;
    end else if (ld_start) begin
      tgt_q <= dest_addr;
      reg_q <= reg_sel;
      cnt_q <= count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (ld_addr) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (ld_data) data_q <= data_d;
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;

  always_comb begin
    rf_we       = 1'b0;
    rf_waddr    = reg_q;
    rf_wdata    = '0;
    mem_req     = 1'b0;
    mem_we      = 1'b0;
    done        = 1'b0;
    illegal_req = 1'b0;
    unique case (state_q)
      ST_TRAP: illegal_req = 1'b1;
      ST_C_SPDEC: begin
        rf_we    = 1'b1;
        rf_waddr = SP_A;
        rf_wdata = sp_in - STEP_V;
      end
      ST_C_PUSH: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
      end
      ST_C_LINK: begin
        rf_we    = 1'b1;
        rf_wdata = pc_in;
      end
      ST_C_JUMP: begin
        rf_we    = 1'b1;
        rf_waddr = PC_A;
        rf_wdata = tgt_q;
        done     = 1'b1;
      end
      ST_R_PC, ST_M_PC: begin
        rf_we    = 1'b1;
        rf_waddr = PC_A;
        rf_wdata = rf_rdata;
      end
      ST_M_SP: begin
        rf_we    = 1'b1;
        rf_waddr = SP_A;
        rf_wdata = pc_in + mark_off;
      end
      ST_P_READ: mem_req = 1'b1;
      ST_P_INC: begin
        rf_we    = 1'b1;
        rf_waddr = SP_A;
        rf_wdata = addr_q + STEP_V;
      end
      ST_P_WRITE: begin
        rf_we    = 1'b1;
        rf_wdata = data_q;
        done     = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/link_seq.sv
module link_seq
  import sls_pkg::*;
#(
  parameter int DW     = 16,
  parameter int NREGS  = 8,
  parameter int SP_IDX = 6,
  parameter int PC_IDX = 7,
  parameter int FP_IDX = 5,
  parameter int STEP   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [15:0]              instr,
  input  logic [DW-1:0]            dest_addr,
  output logic [$clog2(NREGS)-1:0] rf_raddr,
  input  logic [DW-1:0]            rf_rdata,
  input  logic [DW-1:0]            sp_in,
  input  logic [DW-1:0]            pc_in,
  output logic                     rf_we,
  output logic [$clog2(NREGS)-1:0] rf_waddr,
  output logic [DW-1:0]            rf_wdata,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [DW-1:0]            mem_addr,
  output logic [DW-1:0]            mem_wdata,
  input  logic [DW-1:0]            mem_rdata,
  input  logic                     mem_ack,
  output logic                     done,
  output logic                     illegal_req
);

  localparam int REG_W = $clog2(NREGS);

  logic             is_call, is_ret, is_mark, call_bad;
  logic [REG_W-1:0] reg_sel, reg_q;
  logic [5:0]       count;
  seq_state_t       state_q;

  sls_decode #(.REG_W(REG_W), .FP_IDX(FP_IDX)) u_dec (
    .instr    (instr),
    .is_call  (is_call),
    .is_ret   (is_ret),
    .is_mark  (is_mark),
    .call_bad (call_bad),
    .reg_sel  (reg_sel),
    .count    (count)
  );

  sls_ctrl #(.REG_W(REG_W), .PC_IDX(PC_IDX)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .is_call  (is_call),
    .is_ret   (is_ret),
    .is_mark  (is_mark),
    .call_bad (call_bad),
    .reg_q    (reg_q),
    .mem_ack  (mem_ack),
    .state_q  (state_q)
  );

  sls_dpath #(
    .DW(DW), .REG_W(REG_W), .SP_IDX(SP_IDX), .PC_IDX(PC_IDX), .STEP(STEP)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_q     (state_q),
    .start       (start),
    .dest_addr   (dest_addr),
    .reg_sel     (reg_sel),
    .count       (count),
    .rf_rdata    (rf_rdata),
    .sp_in       (sp_in),
    .pc_in       (pc_in),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .reg_q       (reg_q),
    .rf_we       (rf_we),
    .rf_waddr    (rf_waddr),
    .rf_wdata    (rf_wdata),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .done        (done),
    .illegal_req (illegal_req)
  );

  assign rf_raddr = reg_q;

endmodule

// File: rtl/link_seq_chk.sv
module link_seq_chk #(
  parameter int DW     = 16,
  parameter int NREGS  = 8,
  parameter int SP_IDX = 6,
  parameter int STEP   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rf_we,
  input logic [$clog2(NREGS)-1:0] rf_waddr,
  input logic [DW-1:0]            rf_wdata,
  input logic                     mem_req,
  input logic                     mem_we,
  input logic [DW-1:0]            mem_addr,
  input logic [DW-1:0]            mem_wdata,
  input logic                     mem_ack,
  input logic                     done,
  input logic                     illegal_req
);

  localparam int REG_W = $clog2(NREGS);

  // R7: an unacknowledged access stays put
  p_mem_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R8: done marks a register write and lasts one cycle
  p_done_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rf_we);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: trap request is a lone quiet pulse
  p_trap_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_req |-> !rf_we && !mem_req && !done);
  p_trap_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_req |=> !illegal_req);

  // R2: a push goes to the SP value written just before it
  p_push_at_sp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) && mem_we |->
      $past(rf_we) && $past(rf_waddr) == REG_W'(SP_IDX) && $past(rf_wdata) == mem_addr);

  // R4: a completed pop is followed by SP = popped address + step
  p_pop_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_req && mem_ack && !mem_we) |->
      rf_we && rf_waddr == REG_W'(SP_IDX) && rf_wdata == $past(mem_addr) + DW'(STEP));

  // R10: outputs quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r10: assert (!rf_we && !mem_req && !done && !illegal_req);
    end
  end

endmodule

bind link_seq link_seq_chk #(.DW(DW), .NREGS(NREGS), .SP_IDX(SP_IDX), .STEP(STEP)) u_chk (.*);

// File: tb/link_seq_test.sv
module link_seq_test;

  localparam int DW = 16;
  localparam int K_RF = 0, K_MW = 1, K_MR = 2, K_DONE = 3, K_TRAP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [15:0]   instr = '0;
  logic [DW-1:0] dest_addr = '0;
  logic [2:0]    rf_raddr;
  logic [DW-1:0] rf_rdata, sp_in, pc_in;
  logic          rf_we;
  logic [2:0]    rf_waddr;
  logic [DW-1:0] rf_wdata;
  logic          mem_req, mem_we;
  logic [DW-1:0] mem_addr, mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_ack = 1'b0;
  logic          done, illegal_req;

  always #2 clk = ~clk;

  link_seq uut (.*);

  logic [DW-1:0] regs [8];
  logic [DW-1:0] mem  [256];
  int lat = 0;
  int wcnt = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  assign rf_rdata = regs[rf_raddr];
  assign sp_in    = regs[6];
  assign pc_in    = regs[7];

  always @(posedge clk) if (rf_we) regs[rf_waddr] <= rf_wdata;

  // memory responder with programmable latency
  always @(posedge clk) begin
    #1;
    if (mem_req && !mem_ack) begin
      if (wcnt >= lat) begin
        mem_ack = 1'b1;
        if (mem_we) mem[mem_addr[8:1]] = mem_wdata;
        else        mem_rdata = mem[mem_addr[8:1]];
        wcnt = 0;
      end else wcnt++;
    end else mem_ack = 1'b0;
  end

  typedef struct { int kind; int addr; int data; string tag; } ev_t;
  ev_t q[$];

  task automatic expect_ev(int kind, int addr, int data, string tag);
    ev_t e;
    e.kind = kind; e.addr = addr; e.data = data; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic observe(int kind, int addr, int data);
    ev_t e;
    checks++;
    if (q.size() == 0) begin
      fails++;
      $display("FAIL unexpected event (R1 R6 R9): actual kind=%0d addr=%h data=%h expected none",
               kind, addr, data);
    end else begin
      e = q.pop_front();
      if (e.kind != kind || e.addr != addr || e.data != data) begin
        fails++;
        $display("FAIL %s: actual kind=%0d addr=%h data=%h expected kind=%0d addr=%h data=%h",
                 e.tag, kind, addr, data, e.kind, e.addr, e.data);
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (rf_we) observe(K_RF, int'(rf_waddr), int'(rf_wdata));
      if (mem_req && mem_ack) observe(mem_we ? K_MW : K_MR, int'(mem_addr), mem_we ? int'(mem_wdata) : 0);
      if (done) observe(K_DONE, 0, 0);
      if (illegal_req) observe(K_TRAP, 0, 0);
    end
  end

  task automatic drain(string tag);
    int n = 0;
    while (q.size() != 0 && n < 200) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL %s: actual %0d events outstanding expected 0", tag, q.size());
      q.delete();
    end
  endtask

  task automatic pulse(logic [15:0] w, logic [DW-1:0] d);
    @(negedge clk);
    instr = w; dest_addr = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dest_addr = 16'hDEAD;   // R11: later changes must not matter
    instr = 16'h0000;
  endtask

  task automatic do_call(logic [2:0] link, logic [2:0] mode, logic [DW-1:0] d);
    logic [DW-1:0] sp = regs[6];
    logic [DW-1:0] pc = regs[7];
    string t = (link == 3'd7) ? "R3" : "R2";
    if (mode == 3'd0) expect_ev(K_TRAP, 0, 0, "R6");
    else begin
      expect_ev(K_RF, 6, int'(sp - 16'd2), t);
      expect_ev(K_MW, int'(sp - 16'd2), int'(regs[link]), "R7 push");
      if (link != 3'd7) expect_ev(K_RF, int'(link), int'(pc), t);
      expect_ev(K_RF, 7, int'(d), "R11 target");
      expect_ev(K_DONE, 0, 0, "R8");
    end
    pulse({7'b0000100, link, mode, 3'd2}, d);
  endtask

  task automatic do_ret(logic [2:0] r);
    logic [DW-1:0] sp = regs[6];
    expect_ev(K_RF, 7, int'(regs[r]), "R4 pc");
    expect_ev(K_MR, int'(sp), 0, "R7 pop");
    expect_ev(K_RF, 6, int'(sp + 16'd2), "R4 sp");
    expect_ev(K_RF, int'(r), int'(mem[sp[8:1]]), "R4 reg");
    expect_ev(K_DONE, 0, 0, "R8");
    pulse({13'b0000000010000, r}, 16'h0);
  endtask

  task automatic do_mark(logic [5:0] n);
    logic [DW-1:0] spn = regs[7] + 16'(n) * 16'd2;
    expect_ev(K_RF, 6, int'(spn), "R5 sp");
    expect_ev(K_RF, 7, int'(regs[5]), "R5 pc");
    expect_ev(K_MR, int'(spn), 0, "R5 pop");
    expect_ev(K_RF, 6, int'(spn + 16'd2), "R5 inc");
    expect_ev(K_RF, 5, int'(mem[spn[8:1]]), "R5 r5");
    expect_ev(K_DONE, 0, 0, "R8");
    pulse({10'b0000110100, n}, 16'h0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = 16'h1000 + 16'(i * 16'h11);
    for (int i = 0; i < 256; i++) mem[i] = 16'hA000 + 16'(i * 3);
    regs[6] = 16'h0100;
    regs[7] = 16'h0040;
    repeat (3) @(negedge clk);
    checks++;
    if (rf_we || mem_req || done || illegal_req) begin
      fails++;
      $display("FAIL R10: actual we=%b req=%b done=%b ill=%b expected all 0",
               rf_we, mem_req, done, illegal_req);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    lat = 0; do_call(3'd5, 3'd3, 16'h0080); drain("R2 call r5");
    lat = 2; do_ret(3'd5);                   drain("R4 ret r5");
    lat = 1; do_call(3'd7, 3'd1, 16'h00C0); drain("R3 call pc");
    lat = 3; do_ret(3'd7);                   drain("R4 ret pc");
    lat = 0; do_call(3'd2, 3'd6, 16'h0120); drain("R2 call r2");
    lat = 2; do_call(3'd4, 3'd0, 16'h0044); drain("R6 illegal");

    do_call(3'd6, 3'd2, 16'h0060);           drain("R2 call sp");
    regs[6] = 16'h0100; regs[7] = 16'h0050; regs[5] = 16'h0090;
    lat = 1; do_mark(6'd3);                  drain("R5 mark 3");
    regs[7] = 16'h0070; regs[5] = 16'h0032;
    lat = 0; do_mark(6'd0);                  drain("R5 mark 0");
    regs[7] = 16'h0010; regs[5] = 16'h0022;
    lat = 2; do_mark(6'd63);                 drain("R5 mark 63");

    // R1: words outside the three encodings
    regs[6] = 16'h0100; regs[7] = 16'h0040;
    pulse(16'o000240, 16'h0);  drain("R1 unknown 000240");
    pulse(16'o000210, 16'h0);  drain("R1 unknown 000210");
    pulse(16'o006300, 16'h0);  drain("R1 unknown 006300");

    // R9: a second start during a call is ignored
    lat = 3;
    do_call(3'd1, 3'd4, 16'h0140);
    @(negedge clk);
    instr = 16'o000205; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain("R9 busy start");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule